// File: doc/BRIEF.md
# Non-maskable interrupt pending logic

This block turns a non-maskable interrupt line into a request for the processor core. It recognizes only a low-to-high transition of the line, not its level. It presents the request together with a fixed vector of 2, so the core needs no acknowledge bus cycle to learn the vector. The input may be asynchronous. It passes through a synchronizer before the edge detector, and so a pulse must stay high for at least two clocks and low for at least two clocks to be seen.

A handshake with the core governs the request. The core pulses a "taken" acknowledge when it enters the handler, and the block then raises an in-service flag. While that flag is high, any new edge is remembered in a single pending bit, and further edges merge into it. The core pulses a return strobe when the handler ends. That strobe clears the in-service flag, and any remembered edge then shows as a new request.

When a select input reports that the local interrupt controller is disabled, the block takes its source from an alternate local interrupt line instead of the dedicated input.

Top module: `nmi_pend_top`

## Requirements
- R1: A rising edge of the selected source raises `irq_req` three clock edges after the input changes: two synchronizer stages and the pending register. A source held high produces only one request.
- R2: `irq_vector` always reads 8'd2. `irq_req` stays high, without any other cycle, until `take_ack` is sampled high.
- R3: An edge that arrives while `in_service` is high is held pending. `irq_req` rises in the cycle right after the clock edge that samples `ret_strobe`.
- R4: Several edges during one service period produce exactly one request after the return. Once that request has been taken and returned, no further request appears.
- R5: `take_ack` sampled while `irq_req` is high sets `in_service` and drops `irq_req` on the next edge. `ret_strobe` sampled while `in_service` is high clears it. `take_ack` without a request has no effect, and `ret_strobe` outside service has no effect.
- R6: With `lic_off` = 1, the source is `lint_alt` and `nmi_raw` is ignored. With `lic_off` = 0, the source is `nmi_raw` and `lint_alt` is ignored.
- R7: Pulses that are two clocks high, separated by two clocks low, are each recognized as a separate edge.
- R8: Reset clears the synchronizer, the pending bit and the in-service flag, so `irq_req` and `in_service` read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_raw | input | 1 | Dedicated interrupt line, may be asynchronous |
| lic_off | input | 1 | Local interrupt controller disabled: selects `lint_alt` |
| lint_alt | input | 1 | Alternate local interrupt line |
| take_ack | input | 1 | Core has entered the handler |
| ret_strobe | input | 1 | Core has returned from the handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 8 | Fixed vector, value 2 |
| in_service | output | 1 | Handler is running |

## Verification
An input change driven at a falling edge shows on `irq_req` after the third rising edge. The bench checks the value after the second rising edge and again after the third, each at a falling edge. A handshake strobe changes `in_service` or `irq_req` after the single rising edge that samples it, and the bench reads the result at the next falling edge. Where a stimulus should have no effect, the bench waits at least four cycles, beyond the longest latency, before it checks that the outputs are unchanged.

// File: rtl/nmi_pend_pkg.sv
package nmi_pend_pkg;
    parameter int unsigned VEC_W = 8;
    localparam logic [VEC_W-1:0] NMI_VECTOR = VEC_W'(2);

    typedef struct packed {
        logic pend;
        logic svc;
    } core_st_t;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/nmi_edge.sv
module nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = din & ~prev_q;

    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/nmi_core.sv
module nmi_core
    import nmi_pend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic take_ack,
    input  logic ret_strobe,
    output logic irq_req,
    output logic in_service
);
    core_st_t st_d, st_q;
    logic     grant;

    always_comb begin
        st_d  = st_q;
        grant = st_q.pend & ~st_q.svc & take_ack;
        // A new edge always lands in the single pending bit; a grant consumes it.
        st_d.pend = rise | (st_q.pend & ~grant);
        if (grant)
            st_d.svc = 1'b1;
        else if (ret_strobe)
            st_d.svc = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req    = st_q.pend & ~st_q.svc;
    assign in_service = st_q.svc;

    assert_ack_enters_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ack && irq_req) |=> (in_service && !irq_req));

    assert_service_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && !ret_strobe) |=> in_service);

    assert_return_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && ret_strobe) |=> !in_service);

    assert_pending_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && irq_req == 1'b0 && st_q.pend && !ret_strobe) |=> st_q.pend);
endmodule

// File: rtl/nmi_pend_top.sv
module nmi_pend_top
    import nmi_pend_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_raw,
    input  logic             lic_off,
    input  logic             lint_alt,
    input  logic             take_ack,
    input  logic             ret_strobe,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector,
    output logic             in_service
);
    logic src, synced, rise;

    assign src = lic_off ? lint_alt : nmi_raw;

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(src), .dout(synced)
    );

    nmi_edge u_edge (
        .clk(clk), .rst_n(rst_n), .din(synced), .rise(rise)
    );

    nmi_core u_core (
        .clk(clk), .rst_n(rst_n), .rise(rise), .take_ack(take_ack),
        .ret_strobe(ret_strobe), .irq_req(irq_req), .in_service(in_service)
    );

    assign irq_vector = NMI_VECTOR;

    assert_service_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_service) |-> $past(irq_req));

    assert_req_from_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(rise) || $past(ret_strobe)));
endmodule

// File: tb/nmi_pend_top_bench.sv
module nmi_pend_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_raw = 1'b0, lic_off = 1'b0, lint_alt = 1'b0;
    logic       take_ack = 1'b0, ret_strobe = 1'b0;
    logic       irq_req, in_service;
    logic [7:0] irq_vector;
    int         n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    nmi_pend_top u_nmi_pend_top (
        .clk(clk), .rst_n(rst_n), .nmi_raw(nmi_raw), .lic_off(lic_off),
        .lint_alt(lint_alt), .take_ack(take_ack), .ret_strobe(ret_strobe),
        .irq_req(irq_req), .irq_vector(irq_vector), .in_service(in_service)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v);
        if (lic_off) lint_alt = v; else nmi_raw = v;
    endtask

    task automatic ack();
        take_ack = 1'b1; step(1); take_ack = 1'b0;
    endtask

    task automatic ret();
        ret_strobe = 1'b1; step(1); ret_strobe = 1'b0;
    endtask

    // Pulse of width w (>=2) on the selected line; checks R1 latency.
    task automatic pulse_chk(input int w);
        drive(1'b1); step(2);
        chk("R1 latency before", int'(irq_req), 0);
        if (w == 2) drive(1'b0);
        step(1);
        chk("R1 latency due", int'(irq_req), 1);
        if (w > 2) begin step(w - 3); drive(1'b0); end
        step(3);
    endtask

    initial begin
        step(2);
        chk("R8 reset req", int'(irq_req), 0);
        chk("R8 reset svc", int'(in_service), 0);
        rst_n = 1'b1; step(2);
        chk("R2 vector", int'(irq_vector), 2);

        // R1/R2/R5 sweep over source select and pulse width
        for (int sel = 0; sel < 2; sel++) begin
            lic_off = sel[0]; step(4);
            for (int w = 2; w <= 5; w++) begin
                pulse_chk(w);
                step(3);
                chk("R2 req held without ack", int'(irq_req), 1);
                chk("R2 vector", int'(irq_vector), 2);
                ack();
                chk("R5 svc set", int'(in_service), 1);
                chk("R5 req drop", int'(irq_req), 0);
                ret();
                chk("R5 svc clear", int'(in_service), 0);
                chk("R4 no extra req", int'(irq_req), 0);
            end
        end

        // R6: deselected line ignored
        lic_off = 1'b1; step(4);
        nmi_raw = 1'b1; step(4); nmi_raw = 1'b0; step(4);
        chk("R6 nmi_raw ignored", int'(irq_req), 0);
        lic_off = 1'b0; step(4);
        lint_alt = 1'b1; step(4); lint_alt = 1'b0; step(4);
        chk("R6 lint_alt ignored", int'(irq_req), 0);

        // R5: strobes without cause are ignored
        ack(); step(4);
        chk("R5 ack w/o req", int'(in_service), 0);
        ret(); step(4);
        chk("R5 ret w/o svc", int'(in_service), 0);
        chk("R5 ret w/o svc req", int'(irq_req), 0);

        // R1: level held high gives one request
        nmi_raw = 1'b1; step(4);
        ack(); step(6); ret(); step(4);
        chk("R1 level single", int'(irq_req), 0);
        nmi_raw = 1'b0; step(4);

        // R3/R4: edges merged during service
        pulse_chk(2); ack();
        for (int k = 0; k < 3; k++) begin
            nmi_raw = 1'b1; step(2); nmi_raw = 1'b0; step(2);
        end
        step(4);
        chk("R3 held during svc", int'(irq_req), 0);
        ret();
        chk("R3 req after return", int'(irq_req), 1);
        ack(); ret(); step(4);
        chk("R4 merged to one", int'(irq_req), 0);

        // R7: back-to-back 2/2 pulses counted twice
        nmi_raw = 1'b1; step(2); nmi_raw = 1'b0; step(1);
        chk("R7 first pulse", int'(irq_req), 1);
        take_ack = 1'b1; step(1); take_ack = 1'b0;
        nmi_raw = 1'b1; step(2); nmi_raw = 1'b0; step(5);
        chk("R7 second held", int'(irq_req), 0);
        ret();
        chk("R7 second pulse", int'(irq_req), 1);

        // R8: reset clears pending request
        rst_n = 1'b0; step(1);
        chk("R8 mid reset req", int'(irq_req), 0);
        rst_n = 1'b1; step(4);
        chk("R8 after reset req", int'(irq_req), 0);
        chk("R8 after reset svc", int'(in_service), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule